// File: doc/BRIEF.md
# Memory Protection Region Register Bank

This block stores the programmable configuration of a memory protection unit with a parameterised number of regions, from zero to sixteen. Each region owns three 32-bit words: a base address word, a size-and-enable word and an access-control word. Software does not address the regions directly. It first writes a region-select register, and then a shared three-word window reads and writes the words of the selected region. A read-only identification word reports how many regions are built in.

The register port is a plain single-cycle port. An address selects one of five registers, a write takes effect on the clock edge where the write enable is high, and read data follows the address combinationally. Every region word also leaves the block on one flat bus, so a permission checker beside it can evaluate all regions in the same cycle. Each write to a region word is followed by a one-cycle invalidate pulse that tells downstream lookup caches their contents may be stale.

The pulse comes from a two-state sequencer. In QUIET it holds the invalidate output low. The transition QUIET to PULSE is taken on an accepted region-word write. PULSE to PULSE is taken when another such write lands in the pulse cycle. PULSE to QUIET is taken on any other cycle. Reset enters QUIET.

Top module: `mpu_region_bank`

## Requirements
- R1: Register addresses 0, 1 and 2 are the base, size and access windows. A read or write there reaches the base, size or access word of the region whose number is held in the select register.
- R2: Address 3 is the select register. A write whose 32-bit value is less than NUM_REGIONS is stored. A write whose value is NUM_REGIONS or larger is ignored, and the old value stays. A read returns the select value in bits 3:0 and zero above.
- R3: The invalidate output is high in the cycle that follows each clock edge where a window write (address 0 to 2) was accepted. It is low in every other cycle.
- R4: After reset, every region word is zero, the select register is zero and invalidate is low.
- R5: Address 4 reads NUM_REGIONS shifted left by 8 bits. Writes to address 4 change nothing.
- R6: With NUM_REGIONS equal to 0, window reads return zero, window writes change nothing, invalidate never rises, and the select register stays zero.
- R7: Addresses 5, 6 and 7 read zero, and writes to them change nothing.
- R8: The export bus carries region i at bits [96*i +: 96]. The base word sits in the lowest 32 bits of that slice, the size word in the middle 32 bits and the access word in the top 32 bits. It always matches the stored words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the addressed register |
| reg_addr | input | 3 | Register select: 0 base, 1 size, 2 access, 3 region select, 4 identification |
| wr_data | input | 32 | Write value |
| rd_data | output | 32 | Read value of the addressed register (combinational) |
| inval_o | output | 1 | One-cycle pulse after each region-word write |
| region_words_o | output | 96*max(NUM_REGIONS,1) | All region words in parallel, 96 bits per region |

## Verification
The hardest case is a rejected select write that comes after a valid non-zero selection. A window access must then still reach that earlier region and not region 0 or a truncated copy of the rejected value. Random select values are drawn from a range wider than the region count, so about a third of them miss. Window writes are mixed between them, and all-ones and exactly-NUM_REGIONS values are aimed at the highest region. A second instance with zero regions shares the same stimulus, which keeps the empty configuration under load all the time.

// File: rtl/mpu_bank_pkg.sv
package mpu_bank_pkg;

    localparam int WORD_W      = 32;
    localparam int SEL_W       = 4;
    localparam int MAX_REGIONS = 16;
    localparam int REGION_W    = 3 * WORD_W;
    localparam int ADDR_W      = 3;
    localparam int ID_SHIFT    = 8;

    typedef enum logic [ADDR_W-1:0] {
        RA_BASE   = 3'd0,
        RA_SIZE   = 3'd1,
        RA_ACCESS = 3'd2,
        RA_SELECT = 3'd3,
        RA_IDENT  = 3'd4
    } reg_addr_e;

    typedef enum logic [1:0] {
        WIN_BASE   = 2'd0,
        WIN_SIZE   = 2'd1,
        WIN_ACCESS = 2'd2,
        WIN_NONE   = 2'd3
    } win_e;

    typedef enum logic {
        ST_QUIET = 1'b0,
        ST_PULSE = 1'b1
    } inval_state_e;

endpackage

// File: rtl/mpu_sel_reg.sv
module mpu_sel_reg
    import mpu_bank_pkg::*;
#(
    parameter int NUM_REGIONS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output logic [SEL_W-1:0]  sel_q
);

    localparam logic [WORD_W:0] LIMIT = (WORD_W+1)'(NUM_REGIONS);

    logic accept;

    // Compare the whole write value, so no high bit can alias into range
    assign accept = wr_en && ({1'b0, wr_data} < LIMIT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else if (accept) begin
            sel_q <= wr_data[SEL_W-1:0];
        end
    end

endmodule

// File: rtl/mpu_region_store.sv
module mpu_region_store
    import mpu_bank_pkg::*;
#(
    parameter int NUM_REGIONS = 8,
    parameter int FLAT_W      = REGION_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  win_e              win,
    input  logic [SEL_W-1:0]  sel,
    input  logic [WORD_W-1:0] wr_data,
    output logic [FLAT_W-1:0] words_o,
    output logic [WORD_W-1:0] rd_word
);

    generate
        if (NUM_REGIONS > 0) begin : g_bank
            logic [NUM_REGIONS*WORD_W-1:0] pick_flat;

            for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_rgn
                logic [WORD_W-1:0] base_q;
                logic [WORD_W-1:0] size_q;
                logic [WORD_W-1:0] acc_q;
                logic              chosen;
                logic [WORD_W-1:0] view;

                assign chosen = (sel == SEL_W'(g));

                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) begin
                        base_q <= '0;
                        size_q <= '0;
                        acc_q  <= '0;
                    end else if (wr_en && chosen) begin
                        case (win)
                            WIN_BASE:   base_q <= wr_data;
                            WIN_SIZE:   size_q <= wr_data;
                            WIN_ACCESS: acc_q  <= wr_data;
                            default:    ;
                        endcase
                    end
                end

                always_comb begin
                    case (win)
                        WIN_BASE:   view = base_q;
                        WIN_SIZE:   view = size_q;
                        WIN_ACCESS: view = acc_q;
                        default:    view = '0;
                    endcase
                end

                assign pick_flat[g*WORD_W +: WORD_W] = chosen ? view : '0;

                assign words_o[g*REGION_W            +: WORD_W] = base_q;
                assign words_o[g*REGION_W + WORD_W   +: WORD_W] = size_q;
                assign words_o[g*REGION_W + 2*WORD_W +: WORD_W] = acc_q;
            end

            // At most one region is chosen, so an OR of the picks is the mux
            always_comb begin
                rd_word = '0;
                for (int i = 0; i < NUM_REGIONS; i++) begin
                    rd_word = rd_word | pick_flat[i*WORD_W +: WORD_W];
                end
            end
        end else begin : g_empty
            assign words_o = '0;
            assign rd_word = '0;
        end
    endgenerate

endmodule

// File: rtl/mpu_inval_fsm.sv
module mpu_inval_fsm
    import mpu_bank_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    output logic inval_o
);

    inval_state_e state_q;
    inval_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_QUIET;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_QUIET: state_d = fire ? ST_PULSE : ST_QUIET;
            ST_PULSE: state_d = fire ? ST_PULSE : ST_QUIET;
        endcase
    end

    always_comb begin
        inval_o = (state_q == ST_PULSE);
    end

endmodule

// File: rtl/mpu_read_mux.sv
module mpu_read_mux
    import mpu_bank_pkg::*;
#(
    parameter int NUM_REGIONS = 8
) (
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [WORD_W-1:0] win_word,
    input  logic [SEL_W-1:0]  sel,
    output logic [WORD_W-1:0] rd_data
);

    localparam logic [WORD_W-1:0] ID_WORD = WORD_W'(NUM_REGIONS) << ID_SHIFT;

    always_comb begin
        case (reg_addr)
            RA_BASE, RA_SIZE, RA_ACCESS: rd_data = win_word;
            RA_SELECT:                   rd_data = {{(WORD_W-SEL_W){1'b0}}, sel};
            RA_IDENT:                    rd_data = ID_WORD;
            default:                     rd_data = '0;
        endcase
    end

endmodule

// File: rtl/mpu_region_bank.sv
module mpu_region_bank
    import mpu_bank_pkg::*;
#(
    parameter  int NUM_REGIONS = 8,
    localparam int FLAT_W      = ((NUM_REGIONS > 0) ? NUM_REGIONS : 1) * REGION_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] rd_data,
    output logic              inval_o,
    output logic [FLAT_W-1:0] region_words_o
);

    win_e              win;
    logic              win_wr;
    logic              sel_wr;
    logic              fire;
    logic [SEL_W-1:0]  sel_q;
    logic [WORD_W-1:0] win_word;

    always_comb begin
        case (reg_addr)
            RA_BASE:   win = WIN_BASE;
            RA_SIZE:   win = WIN_SIZE;
            RA_ACCESS: win = WIN_ACCESS;
            default:   win = WIN_NONE;
        endcase
    end

    assign win_wr = wr_en && (win != WIN_NONE);
    assign sel_wr = wr_en && (reg_addr == RA_SELECT);
    assign fire   = win_wr && (NUM_REGIONS > 0);

    mpu_sel_reg #(
        .NUM_REGIONS(NUM_REGIONS)
    ) u_sel (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (sel_wr),
        .wr_data (wr_data),
        .sel_q   (sel_q)
    );

    mpu_region_store #(
        .NUM_REGIONS(NUM_REGIONS),
        .FLAT_W     (FLAT_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (win_wr),
        .win     (win),
        .sel     (sel_q),
        .wr_data (wr_data),
        .words_o (region_words_o),
        .rd_word (win_word)
    );

    mpu_inval_fsm u_inval (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire    (fire),
        .inval_o (inval_o)
    );

    mpu_read_mux #(
        .NUM_REGIONS(NUM_REGIONS)
    ) u_rmux (
        .reg_addr (reg_addr),
        .win_word (win_word),
        .sel      (sel_q),
        .rd_data  (rd_data)
    );

endmodule

// File: rtl/mpu_region_bank_chk.sv
module mpu_region_bank_chk
    import mpu_bank_pkg::*;
#(
    parameter int NUM_REGIONS = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [WORD_W-1:0] wr_data,
    input logic [WORD_W-1:0] rd_data,
    input logic              inval_o,
    input logic [SEL_W-1:0]  sel_q
);

    logic win_wr;
    logic bad_sel_wr;

    assign win_wr     = wr_en && (reg_addr <= 3'd2);
    assign bad_sel_wr = wr_en && (reg_addr == 3'd3) && ({1'b0, wr_data} >= (WORD_W+1)'(NUM_REGIONS));

    AST_SEL_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(sel_q) < NUM_REGIONS) || (sel_q == '0)) else $error("select out of range"); // R2

    AST_SEL_HOLD_ON_BAD: assert property (@(posedge clk) disable iff (!rst_n)
        bad_sel_wr |=> $stable(sel_q)) else $error("rejected select changed state"); // R2

    AST_INVAL_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (win_wr && (NUM_REGIONS > 0)) |=> inval_o) else $error("missing invalidate"); // R3

    AST_INVAL_ONLY_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !(win_wr && (NUM_REGIONS > 0)) |=> !inval_o) else $error("spurious invalidate"); // R3

    AST_ID_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 3'd4) |-> (rd_data == (WORD_W'(NUM_REGIONS) << ID_SHIFT))) else $error("bad id word"); // R5

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr >= 3'd5) |-> (rd_data == '0)) else $error("unmapped read not zero"); // R7

endmodule

bind mpu_region_bank mpu_region_bank_chk #(
    .NUM_REGIONS(NUM_REGIONS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .reg_addr (reg_addr),
    .wr_data  (wr_data),
    .rd_data  (rd_data),
    .inval_o  (inval_o),
    .sel_q    (sel_q)
);

// File: tb/tb_mpu_region_bank.sv
module tb_mpu_region_bank;

    localparam int CLK_PERIOD = 10;
    localparam int NR         = 8;
    localparam int FLAT_W     = NR * 96;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [2:0]        reg_addr = 3'd0;
    logic [31:0]       wr_data = 32'd0;
    logic [31:0]       rd_data;
    logic              inval_o;
    logic [FLAT_W-1:0] region_words_o;
    logic [31:0]       rd_z;
    logic              inval_z;
    logic [95:0]       words_z;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    logic [31:0] m_base [NR];
    logic [31:0] m_size [NR];
    logic [31:0] m_acc  [NR];
    logic [3:0]  m_sel;

    always #(CLK_PERIOD/2) clk = ~clk;

    mpu_region_bank #(.NUM_REGIONS(NR)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_addr(reg_addr),
        .wr_data(wr_data), .rd_data(rd_data), .inval_o(inval_o),
        .region_words_o(region_words_o)
    );

    mpu_region_bank #(.NUM_REGIONS(0)) dut_zero (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_addr(reg_addr),
        .wr_data(wr_data), .rd_data(rd_z), .inval_o(inval_z),
        .region_words_o(words_z)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(input logic [2:0] a);
        case (a)
            3'd0:    return m_base[m_sel];
            3'd1:    return m_size[m_sel];
            3'd2:    return m_acc[m_sel];
            3'd3:    return {28'd0, m_sel};
            3'd4:    return 32'(NR) << 8;
            default: return 32'd0;
        endcase
    endfunction

    function automatic logic [FLAT_W-1:0] exp_flat();
        logic [FLAT_W-1:0] v;
        for (int i = 0; i < NR; i++) begin
            v[i*96 +: 32]      = m_base[i];
            v[i*96 + 32 +: 32] = m_size[i];
            v[i*96 + 64 +: 32] = m_acc[i];
        end
        return v;
    endfunction

    task automatic check_flat(input string tag);
        n_checks++;
        if (region_words_o !== exp_flat()) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, region_words_o, exp_flat());
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        logic exp_inval;
        @(negedge clk);
        reg_addr = a;
        wr_data  = d;
        wr_en    = 1'b1;
        exp_inval = (a <= 3'd2);
        @(negedge clk);
        wr_en = 1'b0;
        check("R3 invalidate", {31'd0, inval_o}, {31'd0, exp_inval});
        check("R6 zero-region invalidate", {31'd0, inval_z}, 32'd0);
        case (a)
            3'd0: m_base[m_sel] = d;
            3'd1: m_size[m_sel] = d;
            3'd2: m_acc[m_sel]  = d;
            3'd3: if (d < NR) m_sel = d[3:0];
            default: ;
        endcase
    endtask

    task automatic rd(input logic [2:0] a, input string tag);
        @(negedge clk);
        reg_addr = a;
        #1;
        check(tag, rd_data, exp_read(a));
    endtask

    task automatic report();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            report();
        end
    end

    initial begin
        for (int i = 0; i < NR; i++) begin
            m_base[i] = '0; m_size[i] = '0; m_acc[i] = '0;
        end
        m_sel = '0;
        void'($urandom(32'd20240));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R4 reset state
        @(negedge clk); #1;
        check_flat("R4 reset words");
        check("R4 reset invalidate", {31'd0, inval_o}, 32'd0);
        rd(3'd3, "R4 reset select");
        rd(3'd0, "R4 reset base");

        // R5 identification and write ignore
        rd(3'd4, "R5 id word");
        wr(3'd4, 32'hFFFF_FFFF);
        rd(3'd4, "R5 id after write");
        check_flat("R5 id write no effect");

        // R7 unmapped
        for (int a = 5; a < 8; a++) begin
            wr(3'(a), 32'hDEAD_BEEF);
            rd(3'(a), "R7 unmapped read");
        end
        check_flat("R7 unmapped write no effect");

        // R1 routing to highest and lowest region
        wr(3'd3, 32'd7);
        rd(3'd3, "R2 select accepted");
        wr(3'd0, 32'h7000_0000);
        wr(3'd1, 32'h0000_0031);
        wr(3'd2, 32'h0000_1300);
        wr(3'd3, 32'd0);
        wr(3'd0, 32'h0000_1000);
        rd(3'd0, "R1 region0 base");
        wr(3'd3, 32'd7);
        rd(3'd0, "R1 region7 base");
        rd(3'd1, "R1 region7 size");
        rd(3'd2, "R1 region7 access");
        check_flat("R8 export layout");

        // R2 out-of-range selects
        wr(3'd3, 32'(NR));
        rd(3'd3, "R2 select equal limit ignored");
        wr(3'd3, 32'hFFFF_FFFF);
        rd(3'd3, "R2 select all-ones ignored");
        wr(3'd3, 32'h0000_0013);
        rd(3'd3, "R2 select high bits ignored");
        rd(3'd2, "R1 window after rejected select");

        // R6 zero-region instance under the same bus traffic
        for (int a = 0; a < 5; a++) begin
            @(negedge clk);
            reg_addr = 3'(a);
            #1;
            check("R6 zero-region read", rd_z, 32'd0);
        end
        check("R6 zero-region words", words_z[31:0] | words_z[63:32] | words_z[95:64], 32'd0);

        // Random traffic
        for (int k = 0; k < 600; k++) begin
            logic [2:0]  a;
            logic [31:0] d;
            a = 3'($urandom % 8);
            d = $urandom;
            if (a == 3'd3) d = $urandom % 12;
            if ($urandom % 3 != 0) begin
                wr(a, d);
            end else begin
                rd(a, "R1 random read");
                check("R3 idle invalidate", {31'd0, inval_o}, 32'd0);
            end
            if (k % 20 == 0) begin
                rd(3'd3, "R2 random select");
                check_flat("R8 random export");
            end
        end
        check_flat("R8 final export");
        check("R6 final zero-region words", words_z[31:0] | words_z[63:32] | words_z[95:64], 32'd0);
        @(negedge clk);
        reg_addr = 3'd3;
        #1;
        check("R6 zero-region select stays zero", rd_z, 32'd0);

        finished = 1'b1;
        report();
    end

endmodule